// File: doc/BRIEF.md
# SDRAM Power-Up Bring-Up Sequencer

This block drives the command bus of a synchronous DRAM from the moment reset is released until the memory can take ordinary traffic. The bus consists of chip select, row strobe, column strobe, write enable, clock enable, row/column address and bank bits. The block first holds the bus idle (NOP) for a power-up settling time. That time is given in microseconds and converted to clock cycles from a clock-frequency parameter. It then closes every bank with one precharge-all command, issues two auto-refresh commands, and programs the device mode word. Mandatory idle gaps separate the steps. After the last gap it raises a ready flag.

The mode word is assembled from four configuration inputs: burst length code, burst type, CAS latency code and write-burst mode. The operating-mode field and the upper reserved bits are always forced to zero. A latency or burst code that the device does not accept is replaced by a safe value, and a sticky configuration-error flag reports the substitution. All inputs and outputs are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While reset is asserted, and for exactly P = CLK_MHZ*PWRUP_US cycles after it is released, the bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111) with address and bank at zero. Clock enable is high in every cycle.
- R2: In cycle P after reset release, the block issues one precharge (0010) with address bit 10 set, all other address bits zero and bank zero.
- R3: Exactly T_RP NOP cycles follow the precharge, and then the first auto refresh (0001) is issued.
- R4: Each auto refresh is followed by exactly T_RFC NOP cycles. Exactly two refreshes are issued, and the second one's gap ends with the mode-register load.
- R5: The mode load is command 0000 with bank zero. Its address carries burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4 and write-burst mode in bit 9. Bits 8:7 and bits above 9 are zero.
- R6: A CAS latency code of 010 or 011 is placed unchanged. Any other code is replaced by 011, and the configuration-error flag is set.
- R7: Burst codes 000 to 011 are legal for both burst types (bit 3 = 0 sequential, 1 interleaved). Code 111 (whole row) is legal only for sequential. Any other combination is replaced by 011 (length 8), and the configuration-error flag is set.
- R8: Exactly T_MRD NOP cycles follow the mode load. After them, the ready flag rises and stays high, and the bus stays NOP with address and bank zero.
- R9: The configuration inputs affect the bus and the error flag only in the mode-load cycle. The error flag is zero until the cycle after the mode load, and from then on it holds the value decided in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_len | input | 3 | Requested burst length code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | Requested CAS latency code |
| cfg_wr_single | input | 1 | 1 selects single-location writes |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ROW_W | Address bus (precharge-all flag, mode word) |
| ba | output | BANK_W | Bank select |
| init_done | output | 1 | Ready flag, high once bring-up is complete |
| cfg_err | output | 1 | Set when a configuration code was replaced |

## Verification
The bench sweeps all 256 combinations of burst length code, burst type, latency code and write mode through a full bring-up. It compares the bus in every cycle against a timeline built from the wait parameters. It also compares the mode word and error flag against values derived from the legality rules. The sweep separates legal codes placed as given from substituted codes, including the case where a whole-row burst is allowed for one burst type but not the other. Further runs present illegal, inverted configurations in every cycle except the mode-load cycle. These runs show that only that cycle is sampled, and that the error flag neither rises early nor picks up values presented later.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRFC,
    ST_LMR,
    ST_TMRD,
    ST_DONE
  } step_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  localparam int PRE_ALL_BIT = 10;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int CNT_W     = 8,
  parameter int RESET_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= CNT_W'(RESET_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired); // R3

  AST_TMR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
  parameter int ROW_W = 13
) (
  input  logic [2:0]       burst_len,
  input  logic             burst_type,
  input  logic [2:0]       cas_lat,
  input  logic             wr_single,
  output logic [ROW_W-1:0] word,
  output logic             bad
);

  localparam logic [2:0] LAT_SAFE = 3'b011;
  localparam logic [2:0] LEN_SAFE = 3'b011;
  localparam logic [2:0] LEN_ROW  = 3'b111;

  logic       lat_ok, len_ok;
  logic [2:0] lat_eff, len_eff;

  always_comb begin
    lat_ok  = (cas_lat == 3'b010) || (cas_lat == 3'b011);
    len_ok  = (burst_len[2] == 1'b0) || ((burst_len == LEN_ROW) && !burst_type);
    lat_eff = lat_ok ? cas_lat : LAT_SAFE;
    len_eff = len_ok ? burst_len : LEN_SAFE;
    bad     = !(lat_ok && len_ok);
    word        = '0;
    word[2:0]   = len_eff;
    word[3]     = burst_type;
    word[6:4]   = lat_eff;
    word[8:7]   = 2'b00;
    word[9]     = wr_single;
  end

endmodule

// File: rtl/sdr_step_fsm.sv
module sdr_step_fsm
  import sdr_init_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_RP  = 2,
  parameter int T_RFC = 7,
  parameter int T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_over,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output step_e            step
);

  step_e step_q, step_d;
  logic  second_q, second_d;

  always_comb begin
    step_d   = step_q;
    second_d = second_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (step_q)
      ST_PWRUP: if (wait_over) step_d = ST_PRE;
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RP - 1);
        step_d   = ST_TRP;
      end
      ST_TRP:   if (wait_over) step_d = ST_REF;
      ST_REF: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RFC - 1);
        step_d   = ST_TRFC;
      end
      ST_TRFC: if (wait_over) begin
        if (second_q) step_d = ST_LMR;
        else begin
          step_d   = ST_REF;
          second_d = 1'b1;
        end
      end
      ST_LMR: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_MRD - 1);
        step_d   = ST_TMRD;
      end
      ST_TMRD:  if (wait_over) step_d = ST_DONE;
      default:  step_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= ST_PWRUP;
      second_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      second_q <= second_d;
    end
  end

  assign step = step_q;

  AST_CMD_STEPS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_PRE || step_q == ST_REF || step_q == ST_LMR) |=> (step_q != $past(step_q))); // R4

  AST_DONE_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_DONE) |=> (step_q == ST_DONE)); // R8

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
  import sdr_init_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  step_e             step,
  input  logic [ROW_W-1:0]  mode_word,
  output logic [3:0]        cmd,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba
);

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    case (step)
      ST_PRE: begin
        cmd               = CMD_PRE;
        addr[PRE_ALL_BIT] = 1'b1;
      end
      ST_REF: cmd = CMD_REF;
      ST_LMR: begin
        cmd  = CMD_LMR;
        addr = mode_word;
      end
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdr_init_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PWRUP_US = 100,
  parameter int T_RP     = 2,
  parameter int T_RFC    = 7,
  parameter int T_MRD    = 2,
  parameter int ROW_W    = 13,
  parameter int BANK_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_wr_single,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done,
  output logic              cfg_err
);

  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int MAX_WAIT  = max_of4(PWRUP_CYC, T_RP, T_RFC, T_MRD);
  localparam int CNT_W     = $clog2(MAX_WAIT + 1) + 1;
  localparam int AGE_W     = $clog2(PWRUP_CYC + 1) + 1;

  initial begin
    assert (PWRUP_CYC >= 1 && T_RP >= 1 && T_RFC >= 1 && T_MRD >= 1 && ROW_W >= 11);
  end

  step_e            step;
  logic             wait_over, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [ROW_W-1:0] mode_word;
  logic             mode_bad;
  logic [3:0]       cmd;
  logic             err_q;

  sdr_wait_timer #(.CNT_W(CNT_W), .RESET_VAL(PWRUP_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(wait_over)
  );

  sdr_step_fsm #(.CNT_W(CNT_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wait_over(wait_over),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .step(step)
  );

  sdr_mode_word #(.ROW_W(ROW_W)) u_mode (
    .burst_len(cfg_burst_len), .burst_type(cfg_burst_type), .cas_lat(cfg_cas_lat),
    .wr_single(cfg_wr_single), .word(mode_word), .bad(mode_bad)
  );

  sdr_cmd_drive #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_drive (
    .step(step), .mode_word(mode_word), .cmd(cmd), .addr(addr), .ba(ba)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              err_q <= 1'b0;
    else if (step == ST_LMR) err_q <= mode_bad;
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = 1'b1;
  assign init_done = (step == ST_DONE);
  assign cfg_err   = err_q;

  // observation counters for the checks below
  logic [AGE_W-1:0] age_q;
  logic [1:0]       refs_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q  <= '0;
      refs_q <= '0;
    end else begin
      if (age_q < AGE_W'(PWRUP_CYC)) age_q <= age_q + 1'b1;
      if (cmd == CMD_REF && refs_q != 2'd3) refs_q <= refs_q + 1'b1;
    end
  end

  AST_PWRUP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q < AGE_W'(PWRUP_CYC)) |-> (cmd == CMD_NOP)); // R1

  AST_PRE_ALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (addr[PRE_ALL_BIT] && refs_q == 2'd0)); // R2

  AST_TWO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (refs_q == 2'd2)); // R4

  AST_MODE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (addr[8:7] == 2'b00 && addr[ROW_W-1:10] == '0 && ba == '0)); // R5

  AST_MODE_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (addr[6:4] == 3'b010 || addr[6:4] == 3'b011)); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == CMD_NOP && addr == '0)); // R8

  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd) != CMD_LMR) |-> $stable(cfg_err)); // R9

endmodule

// File: tb/tb_sdram_bringup_seq.sv
`timescale 1ns/1ps
module tb_sdram_bringup_seq;

  localparam int CLK_MHZ = 2, PWRUP_US = 5, T_RP = 3, T_RFC = 4, T_MRD = 2;
  localparam int ROW_W = 13, BANK_W = 2;
  localparam int P      = CLK_MHZ * PWRUP_US;
  localparam int I_PRE  = P;
  localparam int I_REF1 = I_PRE + 1 + T_RP;
  localparam int I_REF2 = I_REF1 + 1 + T_RFC;
  localparam int I_LMR  = I_REF2 + 1 + T_RFC;
  localparam int I_DONE = I_LMR + 1 + T_MRD;
  localparam int RUN_LEN = I_DONE + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bl = '0, cl = '0;
  logic bt = 1'b0, ws = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, cfg_err;
  logic [ROW_W-1:0] addr;
  logic [BANK_W-1:0] ba;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sdram_bringup_seq #(.CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .ROW_W(ROW_W), .BANK_W(BANK_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_type(bt), .cfg_cas_lat(cl),
    .cfg_wr_single(ws), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done), .cfg_err(cfg_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [31:0] bus_now();
    return {12'd0, cke, cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  function automatic logic [31:0] bus_exp(input logic [3:0] c, input logic [ROW_W-1:0] a);
    return {12'd0, 1'b1, c, 2'b00, a};
  endfunction

  function automatic logic lat_legal(input logic [2:0] l);
    return (l == 3'd2) || (l == 3'd3);
  endfunction

  function automatic logic len_legal(input logic [2:0] b, input logic t);
    return (b < 3'd4) || (b == 3'd7 && t == 1'b0);
  endfunction

  function automatic logic [ROW_W-1:0] word_exp(input logic [2:0] b, input logic t,
                                                input logic [2:0] l, input logic w);
    int v;
    v = (len_legal(b, t) ? int'(b) : 3) + 8 * int'(t)
      + 16 * (lat_legal(l) ? int'(l) : 3) + 512 * int'(w);
    return ROW_W'(v);
  endfunction

  task automatic run_cfg(input logic [2:0] b, input logic t, input logic [2:0] l,
                         input logic w, input bit glitch);
    logic exp_err;
    logic [3:0] ec;
    logic [ROW_W-1:0] ea;
    string tag;
    exp_err = glitch ? 1'b0 : !(lat_legal(l) && len_legal(b, t));
    rst_n = 1'b0;
    bl = b; bt = t; cl = l; ws = w;
    @(negedge clk); @(negedge clk);
    #1;
    chk("R1 reset bus", bus_now(), bus_exp(4'b0111, '0));
    chk("R8 reset ready", {31'd0, init_done}, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < RUN_LEN; c++) begin
      if (glitch) begin
        if (c == I_LMR) begin bl = b; bt = t; cl = l; ws = w; end
        else begin bl = 3'b101; bt = ~t; cl = 3'b111; ws = ~w; end
      end
      #1;
      ec = 4'b0111; ea = '0; tag = "R1 power-up NOP";
      if (c == I_PRE) begin ec = 4'b0010; ea = ROW_W'(1) << 10; tag = "R2 precharge-all"; end
      else if (c == I_REF1) begin ec = 4'b0001; tag = "R3 first refresh"; end
      else if (c == I_REF2) begin ec = 4'b0001; tag = "R4 second refresh"; end
      else if (c == I_LMR) begin ec = 4'b0000; ea = word_exp(b, t, l, w); tag = "R5 mode load"; end
      else if (c > I_PRE && c < I_REF1) tag = "R3 tRP gap";
      else if (c > I_REF1 && c < I_LMR) tag = "R4 tRFC gap";
      else if (c > I_LMR) tag = "R8 tMRD gap/idle";
      chk(tag, bus_now(), bus_exp(ec, ea));
      chk("R8 ready flag", {31'd0, init_done}, {31'd0, (c >= I_DONE)});
      chk("R9 error flag timing", {31'd0, cfg_err}, {31'd0, (c > I_LMR) ? exp_err : 1'b0});
      if (c == I_LMR) begin
        chk("R6 latency field", {29'd0, addr[6:4]}, {29'd0, lat_legal(l) ? l : 3'd3});
        chk("R7 burst field", {29'd0, addr[2:0]}, {29'd0, len_legal(b, t) ? b : 3'd3});
      end
      if (c == I_LMR + 1 && !glitch) begin
        if (!lat_legal(l)) chk("R6 error on bad latency", {31'd0, cfg_err}, 32'd1);
        if (!len_legal(b, t)) chk("R7 error on bad burst", {31'd0, cfg_err}, 32'd1);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      run_cfg(3'(i), 1'(i >> 3), 3'(i >> 4), 1'(i >> 7), 1'b0);
    // R9: illegal inverted settings everywhere except the mode-load cycle
    run_cfg(3'd2, 1'b0, 3'd2, 1'b0, 1'b1);
    run_cfg(3'd7, 1'b0, 3'd3, 1'b1, 1'b1);
    run_cfg(3'd0, 1'b1, 3'd2, 1'b1, 1'b1);
    summary();
    $finish;
  end

endmodule